// File: doc/BRIEF.md
# Addressable Tap Shift Register Chain

This block is a one-bit serial delay line built from identical 32-stage units. Each unit shifts in one bit on every clock edge where the shift enable is high. A 5-bit address picks which of its stages appears on its tap output, and a separate tail output always carries its deepest stage. The top chains four units tail-to-input, which gives a 128-stage line with a 7-bit tap address.

Holding the address constant turns the block into a fixed delay line of address+1 enabled clocks. Changing the address from cycle to cycle gives an elastic delay, because the tap read is combinational and follows the address in the same cycle. Data enters only serially, one bit per enabled edge. There is no parallel load, and the stored contents are never cleared.

Top module: `tap_chain`

## Requirements
- R1: With tap_addr = N (0 to 127) held, tap_out equals the din value sampled on the (N+1)-th most recent clock edge at which shift_en was 1.
- R2: On a clock edge with shift_en = 0, no stage changes. With the address unchanged, tap_out and last_out keep their values.
- R3: tap_out follows a change of tap_addr in the same cycle, with no added clock of latency, including while shifting is disabled.
- R4: last_out always equals the din value sampled 128 enabled edges earlier, that is stage 127, whatever the address.
- R5: tap_addr bits 6:5 select the unit (0 nearest din) and bits 4:0 select the stage within it. The boundary addresses 31/32, 63/64 and 95/96 give consecutive delays, and address 127 gives the same value as last_out.
- R6: An address that changes on every cycle, with shifting enabled or not, yields on each cycle the stage that address names at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| shift_en | input | 1 | Shift enable, active high |
| din | input | 1 | Serial data into stage 0 |
| tap_addr | input | 7 | Tap select: bits 6:5 unit, bits 4:0 stage |
| tap_out | output | 1 | Combinational read of the addressed stage |
| last_out | output | 1 | Stage 127, the end of the chain |

## Verification
A broken stage or a missing tail-to-input link corrupts a single bit position, so it shows at the ports only when the address points at that stage or past the broken link. The bench therefore sweeps the address across every unit and both sides of each unit boundary, and it compares on every cycle. A stage that shifts when shift_en is low shows on the next cycle on both tap_out and last_out. A fault in the tap select shows in the same cycle the address changes.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  // Default geometry: stages per unit and units per chain.
  localparam int unsigned DEF_DEPTH = 32;
  localparam int unsigned DEF_UNITS = 4;
endpackage

// File: rtl/tapsr_unit.sv
module tapsr_unit #(
  parameter int unsigned DEPTH = tapsr_pkg::DEF_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          shift_en,
  input  logic          din,
  input  logic [AW-1:0] addr,
  output logic          tap_q,
  output logic          tail_q
);
  logic [DEPTH-1:0] stages;

  // Serial entry only; contents hold when not enabled.
  always_ff @(posedge clk) begin
    if (shift_en) stages <= {stages[DEPTH-2:0], din};
  end

  assign tap_q  = stages[addr];
  assign tail_q = stages[DEPTH-1];
endmodule

// File: rtl/tapsr_sel.sv
module tapsr_sel #(
  parameter int unsigned UNITS = tapsr_pkg::DEF_UNITS,
  localparam int unsigned SW = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic [UNITS-1:0] taps,
  input  logic [SW-1:0]    sel,
  output logic             y
);
  generate
    if (UNITS == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign y = taps[0];
    end else begin : g_mux
      assign y = taps[sel];
    end
  endgenerate
endmodule

// File: rtl/tap_chain.sv
module tap_chain #(
  parameter int unsigned DEPTH = tapsr_pkg::DEF_DEPTH,
  parameter int unsigned UNITS = tapsr_pkg::DEF_UNITS,
  localparam int unsigned LAW = $clog2(DEPTH),
  localparam int unsigned UAW = (UNITS > 1) ? $clog2(UNITS) : 0,
  localparam int unsigned AW  = LAW + UAW
) (
  input  logic          clk,
  input  logic          shift_en,
  input  logic          din,
  input  logic [AW-1:0] tap_addr,
  output logic          tap_out,
  output logic          last_out
);
  logic [UNITS:0]   link;
  logic [UNITS-1:0] unit_tap;

  assign link[0] = din;

  genvar u;
  generate
    for (u = 0; u < UNITS; u++) begin : g_unit
      tapsr_unit #(.DEPTH(DEPTH)) u_unit (
        .clk     (clk),
        .shift_en(shift_en),
        .din     (link[u]),
        .addr    (tap_addr[LAW-1:0]),
        .tap_q   (unit_tap[u]),
        .tail_q  (link[u+1])
      );
    end

    if (UNITS > 1) begin : g_sel_hi
      tapsr_sel #(.UNITS(UNITS)) u_sel (
        .taps(unit_tap),
        .sel (tap_addr[AW-1:LAW]),
        .y   (tap_out)
      );
    end else begin : g_sel_one
      tapsr_sel #(.UNITS(1)) u_sel (
        .taps(unit_tap),
        .sel (1'b0),
        .y   (tap_out)
      );
    end
  endgenerate

  assign last_out = link[UNITS];
endmodule

// File: rtl/tap_chain_chk.sv
module tap_chain_chk #(
  parameter int unsigned AW = 7
) (
  input logic          clk,
  input logic          shift_en,
  input logic          din,
  input logic [AW-1:0] tap_addr,
  input logic          tap_out,
  input logic          last_out
);
  logic [1:0] age = 2'd0;
  logic       armed;

  always_ff @(posedge clk) begin
    if (age != 2'd3) age <= age + 2'd1;
  end
  assign armed = (age == 2'd3);

  AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (!armed)
    shift_en |=> (tap_addr != '0 || tap_out == $past(din))); // R1

  AST_IDLE_TAIL_HOLD: assert property (@(posedge clk) disable iff (!armed)
    !shift_en |=> $stable(last_out)); // R2

  AST_IDLE_TAP_HOLD: assert property (@(posedge clk) disable iff (!armed)
    !shift_en |=> (tap_addr != $past(tap_addr) || $stable(tap_out))); // R2

  AST_TOP_TAP_IS_TAIL: assert property (@(posedge clk) disable iff (!armed)
    (tap_addr == '1) |-> (tap_out == last_out)); // R5
endmodule

bind tap_chain tap_chain_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .shift_en(shift_en),
  .din     (din),
  .tap_addr(tap_addr),
  .tap_out (tap_out),
  .last_out(last_out)
);

// File: tb/sim_tap_chain.sv
`timescale 1ns/1ps
module sim_tap_chain;
  localparam int LEN = 128;

  logic       clk = 1'b0;
  logic       shift_en = 1'b0;
  logic       din = 1'b0;
  logic [6:0] tap_addr = '0;
  logic       tap_out, last_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tap_chain u0 (
    .clk(clk), .shift_en(shift_en), .din(din),
    .tap_addr(tap_addr), .tap_out(tap_out), .last_out(last_out)
  );

  typedef struct {
    bit    tap_known;
    bit    exp_tap;
    bit    last_known;
    bit    exp_last;
    string tag;
  } item_t;

  item_t sb[$];
  bit    hist[LEN];
  int    filled = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Driver: applies inputs, pushes the expected view of this cycle, advances the model.
  task automatic step(input bit en, input bit d, input int a, input string tag);
    item_t it;
    @(negedge clk);
    shift_en = en;
    din      = d;
    tap_addr = a[6:0];
    it.tap_known  = (filled > a);
    it.exp_tap    = hist[a];
    it.last_known = (filled == LEN);
    it.exp_last   = hist[LEN-1];
    it.tag        = tag;
    sb.push_back(it);
    if (en) begin
      for (int i = LEN - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
      if (filled < LEN) filled++;
    end
  endtask

  // Monitor: compares outputs shortly after each input change.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        if (it.tap_known) begin
          checks++;
          if (tap_out !== it.exp_tap) begin
            errors++;
            $display("FAIL %s tap_out addr=%0d actual %0b expected %0b",
                     it.tag, tap_addr, tap_out, it.exp_tap);
          end
        end
        if (it.last_known) begin
          checks++;
          if (last_out !== it.exp_last) begin
            errors++;
            $display("FAIL R4 last_out actual %0b expected %0b", last_out, it.exp_last);
          end
        end
      end
    end
  end

  initial begin
    int bounds[10] = '{0, 5, 31, 32, 63, 64, 95, 96, 126, 127};
    // Fill the whole line through address 0 (R1 at delay 1).
    for (int k = 0; k < 140; k++) step(1'b1, next_bit(), 0, "R1");
    // Fixed delays, including each unit boundary (R1, R5).
    foreach (bounds[b]) begin
      for (int k = 0; k < 24; k++)
        step(1'b1, next_bit(), bounds[b], (bounds[b] % 32 == 0 || bounds[b] % 32 == 31) ? "R5" : "R1");
    end
    // Idle: inputs toggle, nothing shifts (R2).
    for (int k = 0; k < 12; k++) step(1'b0, next_bit(), 64, "R2");
    // Idle with a moving address: tap follows in the same cycle (R3).
    for (int k = 0; k < 40; k++) step(1'b0, next_bit(), (k * 29 + 3) % LEN, "R3");
    // Alternating enable at a fixed tap (R2).
    for (int k = 0; k < 30; k++) step(k[0], next_bit(), 40, "R2");
    // Elastic delay: address and enable change every cycle (R6).
    for (int k = 0; k < 300; k++) step(next_bit() | k[1], next_bit(), (k * 37 + 11) % LEN, "R6");
    // Top address mirrors the tail (R5).
    for (int k = 0; k < 10; k++) step(1'b1, next_bit(), 127, "R5");
    @(negedge clk);
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule